// File: doc/BRIEF.md
# Line Sync Pulse Generator

This block drives the horizontal sync line of a parallel video output from a stream of per-packet timing events. The events are single-cycle frame start, frame end, line start and line end markers, plus a data-enable level that covers the active pixels of each line. All of them arrive on the pixel clock. The sync pulse is two pixel clocks wide. It can follow the line markers directly, or it can be placed relative to the data-enable edges. It can also keep running through vertical blanking as a paced train of pulses.

Settings arrive as plain configuration inputs: source mode, marker selection, polarity, a 13-bit active-line skip split into an upper and a lower part, the blanking mode and the blanking pulse count. The block copies them into a shadow set on each frame start, so one frame always runs under a single set of settings. A delayed copy of data-enable is brought out so that the lead-mode pulse can sit ahead of the active pixels without any lookahead.

Top module: `hsync_gen`

## Requirements
- R1: During reset and after it, until the first frame start changes polarity, `hsync` rests at 0. This is the idle level for polarity 0, and every setting resets to 0.
- R2: When `cfgSrcMode` is 00 or 01 and `cfgMarkSel` is 00, a pulse starts on the clock edge that samples `lineStart`. Another starts on the edge that samples `lineEnd`. Every pulse, from any source, lasts exactly 2 clocks.
- R3: `cfgMarkSel` set to 01 pulses on line start only, 10 pulses on line end only, and 11 makes no marker pulses.
- R4: With `cfgInvert` = 1, `hsync` idles high and each pulse drives it low. With 0, it idles low and pulses high.
- R5: `deOut` is `dataEn` delayed by 3 clocks. When `cfgSrcMode` = 10, the pulse starts on the edge that samples the rise of `dataEn`, so it covers the 2 clocks just before `deOut` rises.
- R6: When `cfgSrcMode` = 11, the pulse starts 2 clocks after `deOut` falls, which is 4 edges after the edge that samples the fall of `dataEn`.
- R7: In source modes 10 and 11, the first N qualifying data-enable edges of each frame make no pulse, where N = {`cfgSkipHi`,`cfgSkipLo`}. The count restarts at every frame start.
- R8: When `cfgBlankMode` = 10, a train of `cfgBlankCount` pulses follows the frame end. The first pulse comes one line interval after the edge that samples frame end, and the rest follow at the same interval. The interval is the most recent spacing measured between two line starts within one frame.
- R9: When `cfgBlankMode` = 11, the train starts at frame start instead. Train pulses that fall due between the first data-enable rise and frame end are withheld and not counted, so all `cfgBlankCount` pulses still appear.
- R10: Until a line interval has been measured after reset, trains use a spacing of 2200 clocks.
- R11: Configuration inputs take effect only on a frame-start cycle. Changes made in the middle of a frame do not alter that frame.
- R12: `cfgBlankMode` 00 or 01, or a blanking count of 0, produces no blanking pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | Frame start marker, one cycle |
| frameEnd | input | 1 | Frame end marker, one cycle |
| lineStart | input | 1 | Line start marker, one cycle |
| lineEnd | input | 1 | Line end marker, one cycle |
| dataEn | input | 1 | Active pixel level of a line |
| cfgSrcMode | input | 2 | Pulse source: 0x markers, 10 lead, 11 trail |
| cfgMarkSel | input | 2 | Marker selection in marker mode |
| cfgInvert | input | 1 | Output polarity, 1 = active low |
| cfgSkipHi | input | 5 | Upper bits of the active-line skip |
| cfgSkipLo | input | 8 | Lower bits of the active-line skip |
| cfgBlankMode | input | 2 | Blanking train: 0x off, 10 from end, 11 from start |
| cfgBlankCount | input | 8 | Number of blanking pulses |
| hsync | output | 1 | Horizontal sync output |
| deOut | output | 1 | Data-enable delayed by 3 clocks |

## Verification
The assertions take for granted that every marker is a single cycle wide. They also assume that frame start never shares a cycle with a line marker or a data-enable edge, and that no new trigger arrives while a pulse is still running, so a pulse is never stretched by a retrigger. The stimulus builds each line as one start marker, six cycles of data-enable, an end marker and ten idle cycles. Frames are separated by idle spans long enough for any blanking train to finish before the next frame start. A frame used to test polarity or timing mode never changes those settings in mid-frame.

// File: rtl/hsg_pkg.sv
package hsg_pkg;
  localparam int SKIP_HI_W = 5;
  localparam int SKIP_LO_W = 8;
  localparam int SKIP_W    = SKIP_HI_W + SKIP_LO_W;
  localparam int BLANK_W   = 8;

  typedef enum logic [1:0] {
    SRC_MARK_A = 2'b00,
    SRC_MARK_B = 2'b01,
    SRC_LEAD   = 2'b10,
    SRC_TRAIL  = 2'b11
  } srcMode_e;

  localparam logic [1:0] BLANK_FROM_END   = 2'b10;
  localparam logic [1:0] BLANK_FROM_START = 2'b11;

  typedef struct packed {
    srcMode_e           srcMode;
    logic [1:0]         markSel;
    logic               invert;
    logic [SKIP_W-1:0]  skipLines;
    logic [1:0]         blankMode;
    logic [BLANK_W-1:0] blankCount;
  } cfg_t;

  typedef struct packed {
    logic fire;
    logic invert;
  } ctrlStrobe_t;

  typedef struct packed {
    logic deRise;
    logic deLateFall;
  } dpEvent_t;
endpackage

// File: rtl/hsg_datapath.sv
module hsg_datapath
  import hsg_pkg::*;
#(
  parameter int GAP_W       = 16,
  parameter int DEFAULT_GAP = 2200,
  parameter int PULSE_W     = 2,
  parameter int TRAIL       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataEn,
  input  logic              lineStart,
  input  logic              frameStart,
  input  ctrlStrobe_t       strobe,
  output dpEvent_t          dpEv,
  output logic [GAP_W-1:0]  gapLen,
  output logic              deOut,
  output logic              hsync
);
  localparam int DLY_LEN = PULSE_W + TRAIL + 1;
  localparam int CNT_W   = $clog2(PULSE_W + 1);
  localparam logic [GAP_W-1:0] GAP_MAX  = '1;
  localparam logic [GAP_W-1:0] GAP_INIT = GAP_W'(DEFAULT_GAP);

  // data-enable delay line: output tap sits PULSE_W stages in, late tap at end
  logic [DLY_LEN-1:0] deDly;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) deDly <= '0;
    else       deDly <= {deDly[DLY_LEN-2:0], dataEn};
  end

  assign deOut           = deDly[PULSE_W];
  assign dpEv.deRise     = dataEn & ~deDly[0];
  assign dpEv.deLateFall = deDly[DLY_LEN-1] & ~deDly[DLY_LEN-2];

  // line-start spacing, measured only inside a frame
  logic [GAP_W-1:0] gapCnt;
  logic             lineSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt   <= '0;
      gapLen   <= GAP_INIT;
      lineSeen <= 1'b0;
    end else begin
      if (lineStart) begin
        gapCnt <= '0;
        if (lineSeen) gapLen <= (gapCnt == GAP_MAX) ? GAP_MAX : gapCnt + 1'b1;
      end else if (gapCnt != GAP_MAX) begin
        gapCnt <= gapCnt + 1'b1;
      end
      if (frameStart)     lineSeen <= 1'b0;
      else if (lineStart) lineSeen <= 1'b1;
    end
  end

  // fixed-width pulse shaper
  logic [CNT_W-1:0] pulseLeft;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pulseLeft <= '0;
    else if (strobe.fire)     pulseLeft <= CNT_W'(PULSE_W);
    else if (pulseLeft != '0) pulseLeft <= pulseLeft - 1'b1;
  end

  assign hsync = (pulseLeft != '0) ^ strobe.invert;
endmodule

// File: rtl/hsg_control.sv
module hsg_control
  import hsg_pkg::*;
#(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             frameEnd,
  input  logic             lineStart,
  input  logic             lineEnd,
  input  cfg_t             cfgIn,
  input  dpEvent_t         dpEv,
  input  logic [GAP_W-1:0] gapLen,
  output ctrlStrobe_t      strobe,
  output cfg_t             liveCfg
);
  localparam logic [SKIP_W-1:0] SKIP_MAX = '1;

  // settings shadow: new values apply from the frame-start cycle on
  cfg_t shadowCfg, live;
  assign live    = frameStart ? cfgIn : shadowCfg;
  assign liveCfg = live;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shadowCfg <= '0;
    else if (frameStart) shadowCfg <= cfgIn;
  end

  // marker-driven pulses
  logic markFire;
  assign markFire = ~live.srcMode[1] &
                    ((lineStart & ~live.markSel[1]) | (lineEnd & ~live.markSel[0]));

  // data-enable driven pulses with line skip
  logic              lineEvt, lineFire;
  logic [SKIP_W-1:0] lineCnt;
  always_comb begin
    case (live.srcMode)
      SRC_LEAD:  lineEvt = dpEv.deRise;
      SRC_TRAIL: lineEvt = dpEv.deLateFall;
      default:   lineEvt = 1'b0;
    endcase
  end
  assign lineFire = lineEvt & (lineCnt >= live.skipLines);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                lineCnt <= '0;
    else if (frameStart)                      lineCnt <= '0;
    else if (lineEvt && lineCnt != SKIP_MAX)  lineCnt <= lineCnt + 1'b1;
  end

  // active zone: first data-enable rise up to frame end
  logic zone;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      zone <= 1'b0;
    else if (frameStart || frameEnd) zone <= 1'b0;
    else if (dpEv.deRise)           zone <= 1'b1;
  end

  // blanking pulse train
  logic               trainOn, feArm, fsArm, trainFire;
  logic [GAP_W-1:0]   trainTimer, gapReload;
  logic [BLANK_W-1:0] trainLeft;

  assign gapReload = gapLen - 1'b1;
  assign fsArm     = (live.blankMode == BLANK_FROM_START) && (live.blankCount != '0);
  assign feArm     = frameEnd && (live.blankMode == BLANK_FROM_END);
  assign trainFire = trainOn && (trainTimer == '0) && !zone && !frameStart && !feArm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trainOn    <= 1'b0;
      trainTimer <= '0;
      trainLeft  <= '0;
    end else if (frameStart) begin
      trainOn    <= fsArm;
      trainTimer <= gapReload;
      trainLeft  <= live.blankCount;
    end else if (feArm) begin
      trainOn    <= (live.blankCount != '0);
      trainTimer <= gapReload;
      trainLeft  <= live.blankCount;
    end else if (trainOn) begin
      if (trainTimer == '0) begin
        trainTimer <= gapReload;
        if (!zone) begin
          trainLeft <= trainLeft - 1'b1;
          if (trainLeft == BLANK_W'(1)) trainOn <= 1'b0;
        end
      end else begin
        trainTimer <= trainTimer - 1'b1;
      end
    end
  end

  assign strobe.fire   = markFire | lineFire | trainFire;
  assign strobe.invert = shadowCfg.invert;
endmodule

// File: rtl/hsync_gen.sv
module hsync_gen
  import hsg_pkg::*;
#(
  parameter int GAP_W       = 16,
  parameter int DEFAULT_GAP = 2200,
  parameter int PULSE_W     = 2,
  parameter int TRAIL       = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameStart,
  input  logic                 frameEnd,
  input  logic                 lineStart,
  input  logic                 lineEnd,
  input  logic                 dataEn,
  input  logic [1:0]           cfgSrcMode,
  input  logic [1:0]           cfgMarkSel,
  input  logic                 cfgInvert,
  input  logic [SKIP_HI_W-1:0] cfgSkipHi,
  input  logic [SKIP_LO_W-1:0] cfgSkipLo,
  input  logic [1:0]           cfgBlankMode,
  input  logic [BLANK_W-1:0]   cfgBlankCount,
  output logic                 hsync,
  output logic                 deOut
);
  cfg_t             cfgIn, liveCfg;
  ctrlStrobe_t      strobe;
  dpEvent_t         dpEv;
  logic [GAP_W-1:0] gapLen;
  logic             invertNow;

  assign cfgIn.srcMode    = srcMode_e'(cfgSrcMode);
  assign cfgIn.markSel    = cfgMarkSel;
  assign cfgIn.invert     = cfgInvert;
  assign cfgIn.skipLines  = {cfgSkipHi, cfgSkipLo};
  assign cfgIn.blankMode  = cfgBlankMode;
  assign cfgIn.blankCount = cfgBlankCount;
  assign invertNow        = strobe.invert;

  hsg_control #(.GAP_W(GAP_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .frameStart(frameStart), .frameEnd(frameEnd),
    .lineStart(lineStart), .lineEnd(lineEnd),
    .cfgIn(cfgIn), .dpEv(dpEv), .gapLen(gapLen),
    .strobe(strobe), .liveCfg(liveCfg)
  );

  hsg_datapath #(
    .GAP_W(GAP_W), .DEFAULT_GAP(DEFAULT_GAP), .PULSE_W(PULSE_W), .TRAIL(TRAIL)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .dataEn(dataEn), .lineStart(lineStart), .frameStart(frameStart),
    .strobe(strobe), .dpEv(dpEv), .gapLen(gapLen),
    .deOut(deOut), .hsync(hsync)
  );
endmodule

// File: rtl/hsg_checker.sv
module hsg_checker
  import hsg_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic hsync,
  input logic deOut,
  input logic invertNow,
  input cfg_t liveCfg
);
  logic act, quietLive, leadOnly, trailOnly;
  assign act       = hsync ^ invertNow;
  assign quietLive = ~liveCfg.srcMode[1] & (liveCfg.markSel == 2'b11) & ~liveCfg.blankMode[1];
  assign leadOnly  = (liveCfg.srcMode == SRC_LEAD)  & ~liveCfg.blankMode[1];
  assign trailOnly = (liveCfg.srcMode == SRC_TRAIL) & ~liveCfg.blankMode[1];

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      idle_in_reset_chk: assert (hsync == 1'b0) else $error("hsync active in reset");
    end
  end

  // R2
  min_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(act) |=> act);

  // R2
  max_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    act && $past(act) |=> !act);

  // R3
  quiet_markers_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(quietLive) && $past(quietLive, 2) |-> !act);

  // R5
  lead_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(act) && leadOnly |-> ##2 $rose(deOut));

  // R6
  trail_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(act) && trailOnly |-> !$past(deOut, 2) && $past(deOut, 3));
endmodule

bind hsync_gen hsg_checker u_chk (
  .clk(clk), .rstN(rstN), .hsync(hsync), .deOut(deOut),
  .invertNow(invertNow), .liveCfg(liveCfg)
);

// File: tb/hsync_gen_tb.sv
`timescale 1ns/1ps
module hsync_gen_tb;
  localparam int D = 6;
  localparam int G = 10;
  localparam int P = D + 2 + G;

  typedef struct { int t; string req; } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic frameStart = 0, frameEnd = 0, lineStart = 0, lineEnd = 0, dataEn = 0;
  logic [1:0] cfgSrcMode = 0, cfgMarkSel = 0, cfgBlankMode = 0;
  logic       cfgInvert = 0;
  logic [4:0] cfgSkipHi = 0;
  logic [7:0] cfgSkipLo = 0, cfgBlankCount = 0;
  logic hsync, deOut;

  int cyc = 0;
  int checks = 0, fails = 0;
  exp_t exq[$];
  exp_t item;
  logic polExp = 0, act, prevAct = 0;
  int runLen = 0;
  int mMode, mSel, mSkip, mBlank, mNum, mGap = 2200, lineIdx;
  string tag;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hsync_gen u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .lineStart(lineStart), .lineEnd(lineEnd), .dataEn(dataEn),
    .cfgSrcMode(cfgSrcMode), .cfgMarkSel(cfgMarkSel), .cfgInvert(cfgInvert),
    .cfgSkipHi(cfgSkipHi), .cfgSkipLo(cfgSkipLo), .cfgBlankMode(cfgBlankMode),
    .cfgBlankCount(cfgBlankCount), .hsync(hsync), .deOut(deOut)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic void expectAt(int t, string r);
    int i = 0;
    while (i < exq.size() && exq[i].t <= t) i++;
    exq.insert(i, '{t, r});
  endfunction

  task automatic check(logic actual, logic expected, string r);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: hsync actual %b expected %b at cycle %0d", r, actual, expected, cyc);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    act = hsync ^ polExp;
    if (act && !prevAct) begin
      checks++;
      if (exq.size() == 0) begin
        fails++;
        $display("FAIL R12: pulse start actual %0d expected none", cyc);
      end else begin
        item = exq.pop_front();
        if (item.t != cyc) begin
          fails++;
          $display("FAIL %s: pulse start actual %0d expected %0d", item.req, cyc, item.t);
        end
      end
      runLen = 1;
    end else if (act) begin
      runLen++;
    end else if (prevAct) begin
      checks++;
      if (runLen != 2) begin
        fails++;
        $display("FAIL R2: pulse width actual %0d expected 2", runLen);
      end
    end
    prevAct = act;
  end

  task automatic driveLine(int c);
    if (mMode < 2) begin
      if (mSel == 0 || mSel == 1) expectAt(c + 1, tag);
      if (mSel == 0 || mSel == 2) expectAt(c + D + 2, tag);
    end else begin
      if (lineIdx >= mSkip) expectAt(mMode == 2 ? c + 2 : c + D + 6, mSkip > 0 ? "R7" : tag);
      lineIdx++;
    end
    lineStart = 1; tick(); lineStart = 0;
    dataEn = 1; repeat (D) tick(); dataEn = 0;
    lineEnd = 1; tick(); lineEnd = 0;
    repeat (G) tick();
  endtask

  task automatic runFrame(int nLines, int pre, int post, int midSel, string r);
    int s, c0, e, gapUse, n, k, x;
    s = cyc; tag = r;
    mMode = cfgSrcMode; mSel = cfgMarkSel; mSkip = {cfgSkipHi, cfgSkipLo};
    mBlank = cfgBlankMode; mNum = cfgBlankCount; lineIdx = 0;
    c0 = s + 1 + pre; e = c0 + nLines * P;
    if (mNum > 0 && mBlank >= 2) begin
      gapUse = (mBlank == 2 && nLines >= 2) ? P : mGap;
      n = 0; k = 1;
      while (n < mNum) begin
        x = (mBlank == 3 ? s + 1 : e + 1) + gapUse * k;
        if (!(mBlank == 3 && nLines > 0 && x - 1 >= c0 + 2 && x - 1 <= e)) begin
          expectAt(x, mBlank == 3 ? "R9" : (gapUse == 2200 ? "R10" : "R8"));
          n++;
        end
        k++;
      end
    end
    frameStart = 1; tick(); frameStart = 0;
    polExp = cfgInvert;
    repeat (pre) tick();
    for (int i = 0; i < nLines; i++) begin
      driveLine(cyc);
      if (i == 0 && midSel >= 0) cfgMarkSel = 2'(midSel);
    end
    frameEnd = 1; tick(); frameEnd = 0;
    repeat (post) tick();
    if (nLines >= 2) mGap = P;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1 rstN = 0;
    repeat (3) tick();
    check(hsync, 1'b0, "R1");
    rstN = 1;
    repeat (2) tick();
    check(hsync, 1'b0, "R1");

    // default spacing before any measurement
    cfgMarkSel = 3; cfgBlankMode = 2; cfgBlankCount = 1;
    runFrame(0, 2, 2300, -1, "R10");
    cfgBlankMode = 0; cfgBlankCount = 0;

    cfgMarkSel = 0; runFrame(3, 4, 20, -1, "R2");
    cfgMarkSel = 1; runFrame(2, 4, 20, -1, "R3");
    cfgMarkSel = 2; runFrame(2, 4, 20, -1, "R3");
    cfgMarkSel = 3; runFrame(2, 4, 20, -1, "R3");

    cfgSrcMode = 2; runFrame(3, 4, 20, -1, "R5");
    cfgSkipLo = 2;  runFrame(4, 4, 20, -1, "R7");
    cfgSrcMode = 3; cfgSkipLo = 0; runFrame(3, 4, 20, -1, "R6");
    cfgSkipLo = 1;  runFrame(3, 4, 20, -1, "R7");
    cfgSkipLo = 0;

    // blanking train after frame end
    cfgSrcMode = 2; cfgBlankMode = 2; cfgBlankCount = 3;
    runFrame(3, 4, 3 * P + 20, -1, "R5");

    // blanking train from frame start, active zone withheld
    cfgSrcMode = 0; cfgMarkSel = 3; cfgBlankMode = 3; cfgBlankCount = 4;
    runFrame(2, 30, 4 * P + 40, -1, "R9");

    // blanking disabled variants
    cfgBlankMode = 2; cfgBlankCount = 0; runFrame(2, 4, 3 * P, -1, "R12");
    cfgBlankMode = 1; cfgBlankCount = 5; runFrame(2, 4, 3 * P, -1, "R12");
    cfgBlankMode = 0; cfgBlankCount = 0;

    // mid-frame change waits for next frame start
    cfgMarkSel = 0; runFrame(3, 4, 20, 3, "R11");

    // polarity
    cfgMarkSel = 1; cfgInvert = 1;
    repeat (3) tick();
    check(hsync, 1'b0, "R11");
    runFrame(2, 4, 20, -1, "R4");
    check(hsync, 1'b1, "R4");
    cfgInvert = 0; cfgMarkSel = 3;
    runFrame(1, 4, 20, -1, "R4");
    check(hsync, 1'b0, "R4");

    repeat (10) tick();
    checks++;
    if (exq.size() != 0) begin
      fails++;
      $display("FAIL %s: pending pulses actual %0d expected 0 (first at %0d)",
               exq[0].req, exq.size(), exq[0].t);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule